// File: doc/BRIEF.md
# I2C Slave Byte-Boundary Clock Stretch Controller

This block decides when an I2C slave pulls SCL low at the end of a byte, and when it lets go. It watches a synchronized copy of SCL, detects each falling edge and counts the clock pulses inside the current byte. The count restarts on a START indication and after every ninth pulse. When stretching is enabled, the block holds SCL low from the falling edge of a chosen pulse. That pulse is the eighth (just before the acknowledge slot) or the ninth (just after it).

While it holds the line, the block raises a stretch flag for software. The line stays low until software writes that flag to zero. Release depends only on that clear; buffer state plays no part. Data shifting, acknowledge generation and address matching belong to neighbouring logic.

The controller is a two-state machine. `ST_COUNT` follows the pulses of the byte, and `ST_HOLD` drives the pull-down and the flag. Transition `COUNT->HOLD` is taken on a falling edge of the selected pulse while stretching is enabled. Transition `HOLD->COUNT` is taken on a software clear. In every other case the machine stays where it is (`COUNT->COUNT`, `HOLD->HOLD`).

Top module: `scl_stretch_ctrl`

## Requirements
- R1: After reset, `scl_hold` and `stretch_flag` are both 0.
- R2: While `stretch_en` is 0, `scl_hold` never goes to 1, whatever the pulses on `scl_in`.
- R3: With `stretch_en`=1 and `stretch_sel`=0, `scl_hold` becomes 1 in the cycle after the ninth falling edge of `scl_in` within a byte is sampled, and not on any earlier edge of that byte.
- R4: With `stretch_en`=1 and `stretch_sel`=1, `scl_hold` becomes 1 in the cycle after the eighth falling edge within a byte is sampled, and the ninth edge of that byte does not stretch.
- R5: `stretch_flag` is 1 exactly in the cycles in which `scl_hold` is 1.
- R6: Once set, `scl_hold` stays 1 until `flag_clr` is sampled high; it is 0 in the cycle after that.
- R7: The pulse count wraps after the ninth falling edge, so every byte of a back-to-back stream is stretched at the same selected pulse.
- R8: A `byte_restart` pulse discards the pulses counted so far; the next falling edge counts as the first of a byte.
- R9: If `flag_clr` is high in the same cycle as the falling edge that starts a stretch, the stretch wins: `scl_hold` and `stretch_flag` go to 1.
- R10: A `flag_clr` pulse while not stretching changes neither output nor the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level, already synchronized to `clk` |
| byte_restart | input | 1 | One-cycle START indication; restarts the pulse count |
| stretch_en | input | 1 | 1 enables stretching at byte boundaries |
| stretch_sel | input | 1 | 0: stretch after the ninth pulse; 1: stretch after the eighth pulse |
| flag_clr | input | 1 | One-cycle software write of the stretch flag to 0 |
| scl_hold | output | 1 | 1 pulls SCL low |
| stretch_flag | output | 1 | Stretch interrupt flag |

## Verification
The bench targets the edges of the pulse count. A counter that is off by one would stretch on the seventh or tenth edge, or would drift from byte to byte in a back-to-back stream. A START indication in the middle of a byte must restart the count, or the next stretch lands early. A clear that arrives on the very edge that starts a stretch must lose; a design that gives it priority would let SCL run free and the byte would go unhandled. A clear sent while idle must leave the count untouched. Randomized bytes mix the enable and select settings with hold times of different lengths.

// File: rtl/scl_stretch_pkg.sv
package scl_stretch_pkg;
    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_HOLD  = 1'b1
    } stretch_state_t;
endpackage

// File: rtl/scl_fall_detect.sv
module scl_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic fall
);
    logic scl_prev;

    // Idle bus is high, so reset to 1 avoids a false edge after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev <= 1'b1;
        else        scl_prev <= scl_in;
    end

    assign fall = scl_prev & ~scl_in;
endmodule

// File: rtl/byte_pulse_counter.sv
module byte_pulse_counter #(
    parameter int PULSES = 9,
    parameter int CNT_W  = $clog2(PULSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (fall) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R7: the count never passes the last pulse of a byte
    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R8: a restart always leaves the count at the first pulse
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/scl_stretch_ctrl.sv
module scl_stretch_ctrl
    import scl_stretch_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic byte_restart,
    input  logic stretch_en,
    input  logic stretch_sel,
    input  logic flag_clr,
    output logic scl_hold,
    output logic stretch_flag
);
    localparam int CNT_W = $clog2(PULSES);
    localparam logic [CNT_W-1:0] IDX_AFTER_ACK  = CNT_W'(PULSES - 1);
    localparam logic [CNT_W-1:0] IDX_BEFORE_ACK = CNT_W'(PULSES - 2);

    logic             fall_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] stop_idx;
    logic             trigger;

    stretch_state_t state, state_nx;

    scl_fall_detect i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .fall   (fall_w)
    );

    byte_pulse_counter #(.PULSES(PULSES), .CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (byte_restart),
        .fall    (fall_w),
        .cnt     (cnt_w)
    );

    // cnt_w holds the number of edges already seen, so index N-1 is the Nth edge
    assign stop_idx = stretch_sel ? IDX_BEFORE_ACK : IDX_AFTER_ACK;
    assign trigger  = fall_w && stretch_en && (cnt_w == stop_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nx;
    end

    // transitions: a trigger beats a clear in the same cycle
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: if (trigger)  state_nx = ST_HOLD;
            ST_HOLD:  if (flag_clr) state_nx = ST_COUNT;
            default:                state_nx = ST_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        scl_hold     = 1'b0;
        stretch_flag = 1'b0;
        unique case (state)
            ST_COUNT: begin
                scl_hold     = 1'b0;
                stretch_flag = 1'b0;
            end
            ST_HOLD: begin
                scl_hold     = 1'b1;
                stretch_flag = 1'b1;
            end
            default: begin
                scl_hold     = 1'b0;
                stretch_flag = 1'b0;
            end
        endcase
    end

    // R2: disabled stretching never pulls the line
    assert_no_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stretch_en && !scl_hold) |=> !scl_hold);

    // R3/R4: a new hold always follows a sampled falling edge
    assert_hold_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(fall_w));

    // R6: hold persists without a clear
    assert_hold_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && !flag_clr) |=> scl_hold);

    // R6: a clear releases the line on the next cycle
    assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && flag_clr) |=> !scl_hold);

    // R9: a clear coinciding with a new stretch loses
    assert_trigger_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_hold && trigger && flag_clr) |=> stretch_flag);
endmodule

// File: tb/test_scl_stretch_ctrl.sv
module test_scl_stretch_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic byte_restart = 1'b0;
    logic stretch_en = 1'b0;
    logic stretch_sel = 1'b0;
    logic flag_clr = 1'b0;
    logic scl_hold;
    logic stretch_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_stretch_ctrl i_scl_stretch_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_in),
        .byte_restart (byte_restart),
        .stretch_en   (stretch_en),
        .stretch_sel  (stretch_sel),
        .flag_clr     (flag_clr),
        .scl_hold     (scl_hold),
        .stretch_flag (stretch_flag)
    );

    function automatic bit exp_stretch(bit en, bit sel, int edge_no);
        return en && (edge_no == (sel ? 8 : 9));
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // both outputs checked; flag must track hold (R5)
    task automatic chk_out(string req, logic exp);
        chk(req, scl_hold, exp);
        chk("R5", stretch_flag, exp);
    endtask

    // one SCL pulse: high then low; sample after the edge is registered
    task automatic pulse();
        @(negedge clk) scl_in = 1'b1;
        @(negedge clk) scl_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_hold(int hold_len);
        for (int k = 0; k < hold_len; k++) begin
            @(negedge clk);
            chk_out("R6", 1'b1);
        end
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk_out("R6", 1'b0);
    endtask

    task automatic run_byte(bit en, bit sel, int hold_len, string req);
        stretch_en  = en;
        stretch_sel = sel;
        for (int e = 1; e <= 9; e++) begin
            pulse();
            if (exp_stretch(en, sel, e)) begin
                chk_out(req, 1'b1);
                release_hold(hold_len);
            end else begin
                chk_out(en ? req : "R2", 1'b0);
            end
        end
    endtask

    initial begin
        int unsigned r;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        chk_out("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1", 1'b0);

        run_byte(1'b0, 1'b0, 1, "R2");
        run_byte(1'b0, 1'b1, 1, "R2");
        run_byte(1'b1, 1'b0, 3, "R3");
        run_byte(1'b1, 1'b1, 2, "R4");
        // back-to-back bytes keep the same stretch point
        run_byte(1'b1, 1'b0, 1, "R7");
        run_byte(1'b1, 1'b0, 1, "R7");
        run_byte(1'b1, 1'b1, 1, "R7");

        // R8: restart mid-byte
        stretch_en = 1'b1; stretch_sel = 1'b0;
        for (int e = 0; e < 4; e++) pulse();
        @(negedge clk) scl_in = 1'b1; byte_restart = 1'b1;
        @(negedge clk) byte_restart = 1'b0;
        run_byte(1'b1, 1'b0, 2, "R8");

        // R10: clear while idle, then the byte still stretches at the 9th edge
        for (int e = 0; e < 3; e++) pulse();
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        @(negedge clk);
        chk_out("R10", 1'b0);
        for (int e = 4; e <= 9; e++) begin
            pulse();
            chk_out("R10", exp_stretch(1'b1, 1'b0, e) ? 1'b1 : 1'b0);
        end
        release_hold(1);

        // R9: clear lands on the same cycle as the 9th edge
        for (int e = 0; e < 8; e++) pulse();
        @(negedge clk) scl_in = 1'b1;
        @(negedge clk) scl_in = 1'b0; flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk_out("R9", 1'b1);
        release_hold(2);

        // random bytes
        for (int b = 0; b < 40; b++) begin
            bit en_r, sel_r;
            r = $urandom();
            en_r  = r[0];
            sel_r = r[1];
            run_byte(en_r, sel_r, 1 + int'(r[4:2]), sel_r ? "R4" : "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule